// File: doc/BRIEF.md
# Pulse Receiver Register Block

This block is the software-facing register bank of a pulse-width receiver. A capture engine sits beside it. That engine measures each incoming pulse in unit intervals and signals a finished measurement with a one-cycle strobe and a width value. The block keeps the latest width, and it holds the ticks-per-interval setting that the engine counts against. It turns each finished measurement into a pending interrupt. A mask gates that pending flag onto an interrupt pin.

Software reaches the bank over a single-beat, valid/ready read and write port in the style of AXI4-Lite, with 32-bit words. A read of the width register acknowledges the interrupt. A self-clearing bit in the control word resets the capture engine and the result state for one cycle. The interval setting survives that reset.

Top module: `pulse_rx_csr`

## Requirements
- R1: After `rst_n` is released, every register reads as zero, and `irq`, `core_rst`, `s_bvalid` and `s_rvalid` are low.
- R2: A write is taken on a clock edge where `s_awvalid`, `s_wvalid` and the ready outputs are high. `s_bvalid` then rises and stays high until `s_bready` is seen. A read is taken when `s_arvalid` and `s_arready` are high. `s_rvalid` then rises with `s_rdata`, and both hold steady until `s_rready` is seen. No new read is taken while `s_rvalid` is high.
- R3: Word 0x04 holds the ticks-per-interval value in bits UI_W-1:0, and its upper bits read as zero. `ui_ticks` shows the stored value. It changes only when word 0x04 is written.
- R4: A `cap_done` strobe stores `cap_width` into bits UI_W-1:0 of word 0x08 and sets the pending flag on the same edge.
- R5: Control word 0x00 has three live bits. Bit 1 is the interrupt enable (1 = enabled). Bit 0 is the soft-reset bit. Bit 31 reads back `irq`. `irq` equals the pending flag ANDed with bit 1. A flag that sets while bit 1 is clear drives `irq` once bit 1 is set.
- R6: A read taken at word 0x08 clears the pending flag on its acceptance edge.
- R7: A `cap_done` strobe on the acceptance edge of a clearing read wins. The flag stays set, and the read returns the width held before that edge.
- R8: Writing 1 to control bit 0 raises `core_rst` for exactly one cycle, starting after the acceptance edge. On the edge that ends that cycle, the pending flag and the width are cleared. The bit then reads 0. The ticks value is kept, and the enable bit takes the value written with the reset.
- R9: Writes to word 0x08, to word 0x0C and to reserved control bits change nothing. Word 0x0C always reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| cap_done | input | 1 | Capture-finished strobe from the engine |
| cap_width | input | UI_W | Measured width in intervals |
| ui_ticks | output | UI_W | Ticks-per-interval setting to the engine |
| core_rst | output | 1 | One-cycle soft reset to the engine |
| irq | output | 1 | Interrupt pin |

## Verification
The bench builds the block with its defaults, ADDR_W = 4 and UI_W = 12. With a 12-bit field, a word written with ones above bit 11 shows the truncation in the value read back. A 4-bit address covers all four word slots, so the unmapped slot at 0x0C can be written and read. With these sizes the bench also reaches the edge where a capture and a clearing read coincide, and the single cycle of the soft reset.

// File: rtl/pulse_rx_csr.sv
module pulse_rx_csr #(
  parameter int ADDR_W = 4,
  parameter int UI_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  input  logic              cap_done,
  input  logic [UI_W-1:0]   cap_width,
  output logic [UI_W-1:0]   ui_ticks,
  output logic              core_rst,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] W_CTRL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_TICKS = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_WIDTH = IDX_W'(2);

  logic            mask_q, rst_q, pend_q;
  logic [UI_W-1:0] ticks_q, width_q;
  logic [31:0]     rd_word;

  wire [IDX_W-1:0] wr_idx = s_awaddr[ADDR_W-1:2];
  wire [IDX_W-1:0] rd_idx = s_araddr[ADDR_W-1:2];
  wire wr_go  = s_awvalid & s_wvalid & ~s_bvalid;
  wire rd_go  = s_arvalid & ~s_rvalid;
  wire rd_clr = rd_go & (rd_idx == W_WIDTH);
  wire unused_bits = ^{s_wdata[31:UI_W], s_awaddr[1:0], s_araddr[1:0]};

  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_arready = ~s_rvalid;
  assign ui_ticks  = ticks_q;
  assign core_rst  = rst_q;
  assign irq       = pend_q & mask_q;

  always_comb begin
    case (rd_idx)
      W_CTRL:  rd_word = {irq, 29'd0, mask_q, rst_q};
      W_TICKS: rd_word = 32'(ticks_q);
      W_WIDTH: rd_word = 32'(width_q);
      default: rd_word = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= 1'b0;
      rst_q    <= 1'b0;
      ticks_q  <= '0;
      s_bvalid <= 1'b0;
    end else begin
      rst_q <= wr_go & (wr_idx == W_CTRL) & s_wdata[0];
      if (wr_go && wr_idx == W_CTRL)  mask_q  <= s_wdata[1];
      if (wr_go && wr_idx == W_TICKS) ticks_q <= s_wdata[UI_W-1:0];
      if (wr_go)                      s_bvalid <= 1'b1;
      else if (s_bready)              s_bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (rd_go) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_word;
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rst_q) begin
      pend_q  <= 1'b0;
      width_q <= '0;
    end else begin
      if (cap_done)    width_q <= cap_width;
      if (cap_done)    pend_q  <= 1'b1;
      else if (rd_clr) pend_q  <= 1'b0;
    end
  end
endmodule

module pulse_rx_csr_chk #(
  parameter int ADDR_W = 4,
  parameter int UI_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic [ADDR_W-1:0] s_awaddr,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [ADDR_W-1:0] s_araddr,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [31:0]       s_rdata,
  input logic              cap_done,
  input logic [UI_W-1:0]   ui_ticks,
  input logic              core_rst,
  input logic              irq,
  input logic              pend_q,
  input logic              mask_q
);
  // R2
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  // R2
  no_read_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
  // R3
  ticks_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ui_ticks) |-> $past(s_awvalid && s_awready && s_awaddr[ADDR_W-1:2] == (ADDR_W-2)'(1)));
  // R4
  cap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && !core_rst |=> pend_q);
  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q && pend_q);
  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid && s_arready && s_araddr[ADDR_W-1:2] == (ADDR_W-2)'(2) && !cap_done |=> !pend_q);
  // R8
  core_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst && !irq);
endmodule

bind pulse_rx_csr pulse_rx_csr_chk #(.ADDR_W(ADDR_W), .UI_W(UI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_awaddr(s_awaddr), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .cap_done(cap_done), .ui_ticks(ui_ticks), .core_rst(core_rst), .irq(irq),
  .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/test_pulse_rx_csr.sv
module test_pulse_rx_csr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [3:0] s_awaddr = 0, s_araddr = 0;
  logic [31:0] s_wdata = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, core_rst, irq;
  logic [31:0] s_rdata;
  logic cap_done = 0;
  logic [11:0] cap_width = 0;
  logic [11:0] ui_ticks;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pulse_rx_csr #(.ADDR_W(4), .UI_W(12)) i_pulse_rx_csr (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1; #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk); s_awvalid = 0; s_wvalid = 0; s_bready = 1;
    @(negedge clk); s_bready = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); s_araddr = a; s_arvalid = 1; #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk); s_arvalid = 0; d = s_rdata; s_rready = 1;
    @(negedge clk); s_rready = 0;
  endtask

  task automatic cap(input logic [11:0] w);
    @(negedge clk); cap_done = 1; cap_width = w;
    @(negedge clk); cap_done = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", irq, 0); chk("R1 core_rst", core_rst, 0);
    chk("R1 bvalid", s_bvalid, 0); chk("R1 rvalid", s_rvalid, 0);
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 ticks", d, 0);
    rd(4'h8, d); chk("R1 width", d, 0);
  endtask

  task automatic t_ticks;
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FABC);
    rd(4'h4, d); chk("R3 ticks upper zero", d, 32'h0000_0ABC);
    chk("R3 ui_ticks", ui_ticks, 12'hABC);
    wr(4'h4, 32'h0000_0031);
    rd(4'h4, d); chk("R3 ticks rewrite", d, 32'h31);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    wr(4'h0, 0);
    cap(12'h3E8);
    chk("R5 masked irq low", irq, 0);
    rd(4'h0, d); chk("R5 ctrl masked", d, 0);
    wr(4'h0, 2);
    chk("R5 pending shows after enable", irq, 1);
    rd(4'h8, d); chk("R4 width", d, 32'h3E8);
    chk("R6 read clears", irq, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    cap(12'h123);
    chk("R5 irq set", irq, 1);
    rd(4'h0, d); chk("R5 ctrl bit31", d, 32'h8000_0002);
    rd(4'h8, d); chk("R4 width 2", d, 32'h123);
    chk("R6 irq cleared", irq, 0);
    rd(4'h0, d); chk("R6 ctrl after clear", d, 32'h2);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    cap(12'h100);
    @(negedge clk); s_araddr = 4'h8; s_arvalid = 1; cap_done = 1; cap_width = 12'h200;
    @(negedge clk); s_arvalid = 0; cap_done = 0;
    chk("R7 old width returned", s_rdata, 32'h100);
    chk("R7 irq kept", irq, 1);
    s_rready = 1; @(negedge clk); s_rready = 0;
    rd(4'h8, d); chk("R7 new width", d, 32'h200);
    chk("R6 cleared after", irq, 0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R9 width write ignored", d, 32'h200);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); chk("R9 slot 0x0C zero", d, 0);
    wr(4'h0, 32'h7FFF_FFFE);
    rd(4'h0, d); chk("R9 reserved ctrl bits", d, 32'h2);
    chk("R9 irq untouched", irq, 0);
  endtask

  task automatic t_handshake;
    @(negedge clk); s_araddr = 4'h4; s_arvalid = 1;
    @(negedge clk); s_arvalid = 0;
    chk("R2 rvalid up", s_rvalid, 1); chk("R2 rdata", s_rdata, 32'h31);
    chk("R2 arready low", s_arready, 0);
    repeat (3) @(negedge clk);
    chk("R2 rvalid held", s_rvalid, 1); chk("R2 rdata held", s_rdata, 32'h31);
    s_rready = 1; @(negedge clk); s_rready = 0;
    chk("R2 rvalid drops", s_rvalid, 0);
    @(negedge clk); s_awaddr = 4'hC; s_wdata = 0; s_awvalid = 1; s_wvalid = 1;
    @(negedge clk); s_awvalid = 0; s_wvalid = 0;
    repeat (3) @(negedge clk);
    chk("R2 bvalid held", s_bvalid, 1);
    s_bready = 1; @(negedge clk); s_bready = 0;
    chk("R2 bvalid drops", s_bvalid, 0);
  endtask

  task automatic t_softrst;
    logic [31:0] d;
    cap(12'h077);
    chk("R8 pending before", irq, 1);
    @(negedge clk); s_awaddr = 4'h0; s_wdata = 32'h3; s_awvalid = 1; s_wvalid = 1;
    @(negedge clk); s_awvalid = 0; s_wvalid = 0; s_bready = 1;
    chk("R8 core_rst high", core_rst, 1);
    @(negedge clk); s_bready = 0;
    chk("R8 core_rst one cycle", core_rst, 0);
    chk("R8 irq cleared", irq, 0);
    rd(4'h0, d); chk("R8 ctrl self-clear", d, 32'h2);
    rd(4'h8, d); chk("R8 width cleared", d, 0);
    rd(4'h4, d); chk("R8 ticks kept", d, 32'h31);
    chk("R8 ui_ticks kept", ui_ticks, 12'h031);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ticks();
    t_masked();
    t_irq();
    t_same_cycle();
    t_ignored();
    t_handshake();
    t_softrst();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule